// File: doc/BRIEF.md
# Bulk Array Fill Command Controller

This block is the command core of a single-wire serial memory slave. A line decoder in front of it delivers whole bytes, each tagged with the acknowledge bit the master sent after it. It also flags each standby pulse it detects. After a standby pulse the controller expects a fixed start header and then the device address. It requests a slave acknowledge for a matching address. It then decodes the command byte. Two commands are handled: erase-all, which fills every array location with 0x00, and set-all, which fills every location with 0xFF.

A fill starts only if four conditions hold. The command byte must be followed by a no-acknowledge from the master. The write-enable latch must be set. Both protect bits must be zero. The code must be one of the two fill codes. If any condition fails, the controller drops back to idle without acknowledging and writes nothing. An accepted fill is acknowledged and then writes one array word per cycle through a plain write port. Busy stays high through a programmable settle time. At the end the write-enable latch clears.

Byte input rules: the input has a valid strobe and no ready. Every byte presented with `in_valid` high is consumed in that cycle, so the block never applies back-pressure. While busy, bytes are consumed and dropped. The memory write port has no handshake either: the array must take one write on every cycle in which `mem_we` is high.

Top module: `fill_cmd_ctrl`

## Requirements
- R1: After reset, busy, mem_we, sak_req and wel are all low, and the controller waits for a standby pulse.
- R2: The first byte after a standby pulse must be 0x55. Any other value returns the controller to idle, and later bytes get no acknowledge until the next standby pulse.
- R3: A device address byte of 0xA0 in the address slot raises sak_req for exactly one cycle, in the cycle after the byte. Any other value returns the controller to idle with no acknowledge.
- R4: Command 0x6D followed by a no-acknowledge (in_mak = 0) starts a fill with 0x00, provided wel = 1 and protect = 2'b00. The cycle after the command byte shows sak_req high and busy high.
- R5: Command 0x67 under the same conditions starts a fill with 0xFF.
- R6: A fill command byte followed by an acknowledge (in_mak = 1) is dropped: no sak_req, no write, and a return to idle.
- R7: A fill command is dropped, with no acknowledge and no write, when the write-enable latch is clear.
- R8: A fill command is dropped, with no acknowledge and no write, when protect is 2'b01, 2'b10 or 2'b11.
- R9: A fill writes addresses 0 to 255 in ascending order, one per cycle, starting in the cycle after the command byte. Busy then stays high for HOLD_CYCLES more cycles (16 by default).
- R10: wren_req sets wel while the controller is not busy. wel clears on the same edge at which busy falls after a fill.
- R11: While busy, bytes, standby pulses and wren_req have no effect, and sak_req stays low.
- R12: A command byte that is neither 0x6D nor 0x67 returns the controller to idle with no acknowledge and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_seen | input | 1 | One-cycle flag marking a detected standby pulse |
| in_valid | input | 1 | Byte strobe; the byte is consumed in this cycle |
| in_byte | input | 8 | Received byte |
| in_mak | input | 1 | Master bit after the byte: 1 = acknowledge, 0 = no-acknowledge |
| wren_req | input | 1 | Write-enable instruction decoded elsewhere |
| protect | input | 2 | Block-protect bits; any nonzero value blocks fills |
| busy | output | 1 | High while a fill and its settle time are in progress |
| sak_req | output | 1 | One-cycle request to send a slave acknowledge |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| wel | output | 1 | Write-enable latch state |

## Verification
Erase-all and set-all are each run to completion. This separates the two fill values and checks the full address sweep and the busy span.

The fill code is also sent in several failing contexts: with an acknowledge instead of a no-acknowledge, with the latch clear, and under each nonzero protect value. Each of these must give no acknowledge and no write, which shows that every gating condition is checked on its own.

Corrupted headers, wrong addresses and an unknown command code check that each frame slot rejects bad input and returns to idle. A complete frame plus a write-enable request sent during a fill shows that a busy controller ignores its inputs.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PROT_W = 2;
  localparam logic [BYTE_W-1:0] START_HDR  = 8'h55;
  localparam logic [BYTE_W-1:0] DEV_ADDR   = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_CLRALL = 8'h6D;
  localparam logic [BYTE_W-1:0] CMD_SETALL = 8'h67;

  typedef enum logic [1:0] {DEC_IDLE, DEC_HDR, DEC_ADDR, DEC_CMD} dec_state_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FILL, SEQ_HOLD} seq_state_t;
endpackage

// File: rtl/fill_frame_decoder.sv
module fill_frame_decoder
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_seen,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_mak,
  input  logic              wel,
  input  logic [PROT_W-1:0] protect,
  input  logic              seq_busy,
  output logic              start,
  output logic [BYTE_W-1:0] fill_val,
  output logic              sak_req
);
  dec_state_t st_q;
  logic       sak_q;
  logic       is_fill_code;

  assign is_fill_code = (in_byte == CMD_CLRALL) || (in_byte == CMD_SETALL);
  assign start = (st_q == DEC_CMD) && in_valid && !standby_seen && is_fill_code
               && !in_mak && wel && (protect == '0);
  assign fill_val = (in_byte == CMD_SETALL) ? '1 : '0;
  assign sak_req  = sak_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= DEC_IDLE;
      sak_q <= 1'b0;
    end else begin
      sak_q <= 1'b0;
      if (standby_seen && !seq_busy) begin
        st_q <= DEC_HDR;
      end else if (in_valid) begin
        case (st_q)
          DEC_HDR:  st_q <= (in_byte == START_HDR) ? DEC_ADDR : DEC_IDLE;
          DEC_ADDR: begin
            if (in_byte == DEV_ADDR) begin
              st_q  <= DEC_CMD;
              sak_q <= 1'b1;
            end else begin
              st_q <= DEC_IDLE;
            end
          end
          DEC_CMD: begin
            st_q  <= DEC_IDLE;
            sak_q <= start;
          end
          default: st_q <= DEC_IDLE;
        endcase
      end
    end
  end

  // R11: no acknowledge is requested out of a busy cycle
  a_r11_no_sak_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sak_req |-> !$past(seq_busy));
  // R3: an acknowledge always answers a consumed byte
  a_r3_sak_answers_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sak_req |-> $past(in_valid));
endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer
  import fill_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] fill_val,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int unsigned TMR_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HOLD_CYCLES - 1);

  seq_state_t        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [BYTE_W-1:0] val_q;

  assign busy      = (st_q != SEQ_IDLE);
  assign mem_we    = (st_q == SEQ_FILL);
  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;
  assign done      = (st_q == SEQ_HOLD) && (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
      tmr_q  <= '0;
      val_q  <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (start) begin
          st_q   <= SEQ_FILL;
          addr_q <= '0;
          val_q  <= fill_val;
        end
        SEQ_FILL: begin
          if (addr_q == '1) begin
            st_q  <= SEQ_HOLD;
            tmr_q <= '0;
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
          end
        end
        SEQ_HOLD: begin
          if (tmr_q == TMR_LAST) st_q <= SEQ_IDLE;
          else tmr_q <= tmr_q + TMR_W'(1);
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // R9: consecutive writes step the address by one
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R9: a sweep begins at address zero
  a_r9_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_addr == '0));
  // R4/R5: the fill value stays constant during a sweep
  a_r5_value_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(mem_wdata));
  // R9: the settle time follows the last write
  a_r9_hold_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we) |-> busy);
endmodule

// File: rtl/fill_cmd_ctrl.sv
module fill_cmd_ctrl
  import fill_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_seen,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_mak,
  input  logic              wren_req,
  input  logic [1:0]        protect,
  output logic              busy,
  output logic              sak_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              wel
);
  logic              start;
  logic              done;
  logic [BYTE_W-1:0] fill_val;
  logic              wel_q;

  assign wel = wel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wel_q <= 1'b0;
    else if (done) wel_q <= 1'b0;
    else if (wren_req && !busy) wel_q <= 1'b1;
  end

  fill_frame_decoder u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_seen (standby_seen),
    .in_valid     (in_valid),
    .in_byte      (in_byte),
    .in_mak       (in_mak),
    .wel          (wel_q),
    .protect      (protect),
    .seq_busy     (busy),
    .start        (start),
    .fill_val     (fill_val),
    .sak_req      (sak_req)
  );

  fill_sequencer #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fill_val  (fill_val),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R10: the latch is clear once a fill has finished
  a_r10_wel_off_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R4 R6 R7 R8: a fill starts only from a guarded no-acknowledge byte
  a_r4_start_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && !in_mak && wel && (protect == 2'b00)));
endmodule

// File: tb/tb_fill_cmd_ctrl.sv
module tb_fill_cmd_ctrl;
  localparam int DEPTH = 256;
  localparam int HOLD  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_seen = 1'b0, in_valid = 1'b0, in_mak = 1'b0, wren_req = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [1:0] protect = 2'b00;
  logic busy, sak_req, mem_we, wel;
  logic [7:0] mem_addr, mem_wdata;

  int checks = 0, errors = 0, cycles = 0, writes = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  fill_cmd_ctrl #(.ADDR_W(8), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .standby_seen(standby_seen), .in_valid(in_valid),
    .in_byte(in_byte), .in_mak(in_mak), .wren_req(wren_req), .protect(protect),
    .busy(busy), .sak_req(sak_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wel(wel));

  // Behavioural reference: phase 0 idle, 1 header, 2 address, 3 command, 4 sweep, 5 settle
  int m_ph = 0, m_cnt = 0;
  bit m_sak = 0, m_wel = 0;
  int m_fill = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sak = 0; m_wel = 0; m_fill = 0;
    end else begin
      m_sak = 0;
      if (m_ph == 4) begin
        if (m_cnt == DEPTH - 1) begin m_ph = 5; m_cnt = 0; end
        else m_cnt++;
      end else if (m_ph == 5) begin
        if (m_cnt == HOLD - 1) begin m_ph = 0; m_cnt = 0; m_wel = 0; end
        else m_cnt++;
      end else begin
        if (standby_seen) m_ph = 1;
        else if (in_valid) begin
          if (m_ph == 1) m_ph = (in_byte == 8'h55) ? 2 : 0;
          else if (m_ph == 2) begin
            if (in_byte == 8'hA0) begin m_ph = 3; m_sak = 1; end else m_ph = 0;
          end else if (m_ph == 3) begin
            if ((in_byte == 8'h6D || in_byte == 8'h67) && !in_mak && m_wel && protect == 2'b00) begin
              m_ph = 4; m_cnt = 0; m_sak = 1;
              m_fill = (in_byte == 8'h67) ? 255 : 0;
            end else m_ph = 0;
          end
        end
        if (wren_req) m_wel = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (mem_we) writes++;
      check(busy == (m_ph >= 4), "R9", "busy", busy, m_ph >= 4);
      check(mem_we == (m_ph == 4), "R9", "mem_we", mem_we, m_ph == 4);
      if (m_ph == 4) begin
        check(mem_addr == m_cnt[7:0], "R9", "mem_addr", mem_addr, m_cnt);
        check(mem_wdata == m_fill[7:0], "R5", "mem_wdata", mem_wdata, m_fill);
      end
      check(sak_req == m_sak, "R3", "sak_req", sak_req, m_sak);
      check(wel == m_wel, "R10", "wel", wel, m_wel);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000 && !done_flag) @(negedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic standby();
    @(negedge clk); standby_seen = 1'b1; @(negedge clk); standby_seen = 1'b0;
  endtask
  task automatic wren();
    @(negedge clk); wren_req = 1'b1; @(negedge clk); wren_req = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, input logic mak);
    @(negedge clk); in_valid = 1'b1; in_byte = b; in_mak = mak;
    @(negedge clk); in_valid = 1'b0; in_mak = 1'b0;
  endtask
  task automatic frame(input logic [7:0] h, input logic [7:0] a, input logic [7:0] c, input logic mak);
    standby(); send(h, 1'b1); idle(1); send(a, 1'b1); send(c, mak);
  endtask
  task automatic wait_idle();
    idle(2);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  int w0;

  initial begin
    idle(3);
    // R1: reset state
    check(!busy && !mem_we && !sak_req && !wel, "R1", "reset outputs", {busy, mem_we, sak_req, wel}, 0);
    rst_n = 1'b1;
    idle(2);

    // R7: fill without write enable
    w0 = writes; frame(8'h55, 8'hA0, 8'h6D, 1'b0); idle(4);
    check(writes == w0 && !busy, "R7", "writes without latch", writes - w0, 0);

    // R4: erase-all
    wren(); w0 = writes; frame(8'h55, 8'hA0, 8'h6D, 1'b0); wait_idle();
    check(writes - w0 == DEPTH, "R4", "erase writes", writes - w0, DEPTH);
    check(!wel, "R10", "latch after erase", wel, 0);

    // R5: set-all
    wren(); w0 = writes; frame(8'h55, 8'hA0, 8'h67, 1'b0); wait_idle();
    check(writes - w0 == DEPTH, "R5", "set writes", writes - w0, DEPTH);

    // R6: acknowledge after command
    wren(); w0 = writes; frame(8'h55, 8'hA0, 8'h67, 1'b1); idle(4);
    check(writes == w0 && wel, "R6", "writes after MAK", writes - w0, 0);

    // R8: each nonzero protect value
    for (int p = 1; p < 4; p++) begin
      protect = p[1:0]; w0 = writes; frame(8'h55, 8'hA0, 8'h6D, 1'b0); idle(4);
      check(writes == w0, "R8", "writes under protect", writes - w0, 0);
    end
    protect = 2'b00;

    // R2: bad header
    w0 = writes; frame(8'h54, 8'hA0, 8'h6D, 1'b0); idle(4);
    check(writes == w0, "R2", "writes after bad header", writes - w0, 0);

    // R3: bad address
    w0 = writes; frame(8'h55, 8'hA2, 8'h6D, 1'b0); idle(4);
    check(writes == w0, "R3", "writes after bad address", writes - w0, 0);

    // R12: unknown command
    w0 = writes; frame(8'h55, 8'hA0, 8'h96, 1'b0); idle(4);
    check(writes == w0, "R12", "writes after unknown code", writes - w0, 0);

    // R11: traffic during a fill
    w0 = writes; frame(8'h55, 8'hA0, 8'h6D, 1'b0);
    idle(5); frame(8'h55, 8'hA0, 8'h67, 1'b0); wren();
    wait_idle();
    check(writes - w0 == DEPTH, "R11", "writes with busy traffic", writes - w0, DEPTH);
    check(!wel, "R11", "latch after busy wren", wel, 0);

    done_flag = 1;
    summary();
  end
endmodule